// File: doc/BRIEF.md
# ADC Channel Status/Control Slice

This block is the control and status word for one conversion channel of a successive-approximation converter. Software writes a 32-bit word that holds an interrupt enable, a differential-mode select and a five-bit input code. The block decodes that code into one-hot input-select lines for the analog multiplexer. It flags codes that are not valid in differential mode, and it treats the all-ones code as "converter off". A write with any other code sends a one-cycle start pulse to the converter core.

The converter core, the compare engine, the averaging accumulator and the calibration engine are outside the block. They appear only as single-cycle strobes: conversion finished, compare true, averaged set finished and calibration finished. A read-only completion flag sets from these strobes. Which strobes count depends on whether compare and averaging are enabled. The flag clears when the word is written or when the matching result register is read. While the flag and the interrupt enable are both 1, an interrupt request is raised.

The block has two state machines. The completion flag machine has two states: `FLG_EMPTY` and `FLG_DONE`. A qualified set event moves it from `FLG_EMPTY` to `FLG_DONE`. A clear event with no set event in the same cycle moves it from `FLG_DONE` back to `FLG_EMPTY`. The conversion sequencer has three states: `SEQ_OFF`, `SEQ_IDLE` and `SEQ_BUSY`. A write with a code other than all-ones moves it from any state to `SEQ_BUSY` and issues a start. A write with the all-ones code moves it from any state to `SEQ_OFF` with no start. When a conversion finishes in `SEQ_BUSY`, the sequencer does one of two things. In continuous mode it stays in `SEQ_BUSY` and restarts. In single mode it goes to `SEQ_IDLE`.

Top module: `adc_chan_ctrl`

## Requirements
- R1: `rd_data` is {24 zero bits, flag at bit 7, interrupt enable at bit 6, differential select at bit 5, input code at bits 4:0}. A write updates bits 6:0 only. Bits 31:8 always read 0. Writing bit 7 as 1 never sets the flag.
- R2: With `cmp_en`=0 and `avg_en`=0, a `conv_done` strobe sets the flag. The flag is visible in `rd_data[7]` in the cycle after the strobe.
- R3: With `cmp_en`=1 and `avg_en`=0, `conv_done` sets the flag only when `cmp_true` is 1 in the same cycle.
- R4: With `avg_en`=1, `conv_done` has no effect on the flag. Instead `avg_done` sets it, and when `cmp_en`=1 it must also be accompanied by `cmp_true`.
- R5: With parameter `PRIMARY`=1, a `cal_done` strobe sets the flag whatever the mode settings.
- R6: A write (`wr_en`) or a result read (`res_rd`) clears the flag from the next cycle on. If a set event arrives in the same cycle as a clear, the flag ends up 1.
- R7: `irq` is 1 exactly while the flag and the interrupt enable bit are both 1.
- R8: A write whose code is not 5'b11111 drives `conv_start` high for the single cycle after the write. A write with code 5'b11111 produces no start and drives `conv_off` high.
- R9: When `cont_mode`=1, a `conv_done` after a start restarts the converter (`conv_start` in the next cycle). Once code 5'b11111 has been written, a later `conv_done` produces no start.
- R10: With differential select 0, code k < 8 drives only `sel_se[k]`. With differential select 1, code k < 4 drives only `sel_pair[k]`, and codes 4 to 7 drive no select and raise `sel_rsvd`. Codes 8 and above select no line. Code 5'b11111 selects nothing.
- R11: After reset, `rd_data` is 32'h0000_001F, `irq` and `conv_start` are 0, and `conv_off` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| res_rd | input | 1 | Result register read strobe (clears flag) |
| cont_mode | input | 1 | Continuous conversion enabled |
| cmp_en | input | 1 | Compare function enabled |
| avg_en | input | 1 | Hardware averaging enabled |
| conv_done | input | 1 | Single conversion finished strobe |
| cmp_true | input | 1 | Compare result true, valid with conv_done/avg_done |
| avg_done | input | 1 | Averaged set finished strobe |
| cal_done | input | 1 | Calibration sequence finished strobe |
| irq | output | 1 | Conversion-complete interrupt request |
| conv_start | output | 1 | One-cycle start pulse to the converter core |
| conv_off | output | 1 | Converter off and input isolated |
| sel_se | output | 8 | One-hot single-ended input select |
| sel_pair | output | 4 | One-hot differential pair select |
| sel_rsvd | output | 1 | Reserved differential code selected |

## Verification
If the flag machine is in the wrong state, the error shows on `rd_data[7]` and, when the enable is set, on `irq`. It appears in the very cycle after the strobe or clear that caused it, so a per-cycle comparison against a behavioural model catches it at once. If the sequencer is in the wrong state, nothing shows until the next `conv_done`. Then a missing or extra `conv_start` appears one cycle later. For this reason the stimulus places conversion strobes both inside and outside continuous runs, and again after the off code. Decoder faults are combinational from the stored word and show in the cycle after the write.

// File: rtl/adc_chan_pkg.sv
package adc_chan_pkg;

    localparam int REG_W   = 32;
    localparam int CODE_W  = 5;
    localparam int FLAG_B  = 7;
    localparam int IEN_B   = 6;
    localparam int DIFF_B  = 5;
    localparam int CFG_W   = CODE_W + 2;
    localparam logic [CODE_W-1:0] OFF_CODE = '1;

    typedef struct packed {
        logic              ien;
        logic              diff;
        logic [CODE_W-1:0] code;
    } cfg_t;

    typedef enum logic {
        FLG_EMPTY = 1'b0,
        FLG_DONE  = 1'b1
    } flg_state_t;

    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,
        SEQ_IDLE = 2'd1,
        SEQ_BUSY = 2'd2
    } seq_state_t;

endpackage

// File: rtl/adc_cfg_reg.sv
module adc_cfg_reg
    import adc_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_cfg,
    output cfg_t             cfg
);

    cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.ien  <= 1'b0;
            cfg_q.diff <= 1'b0;
            cfg_q.code <= OFF_CODE;
        end else if (wr_en) begin
            cfg_q <= cfg_t'(wr_cfg);
        end
    end

    assign cfg = cfg_q;

    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/adc_done_flag.sv
module adc_done_flag
    import adc_chan_pkg::*;
#(
    parameter bit PRIMARY = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_en,
    input  logic avg_en,
    input  logic conv_done,
    input  logic cmp_true,
    input  logic avg_done,
    input  logic cal_done,
    input  logic clr_wr,
    input  logic clr_rd,
    output logic flag
);

    flg_state_t state_q, state_d;
    logic cmp_ok, single_set, avg_set, cal_set, set_evt, clr_evt;

    // Qualification of completion events by the active modes.
    always_comb begin
        cmp_ok     = !cmp_en || cmp_true;
        single_set = !avg_en && conv_done && cmp_ok;
        avg_set    = avg_en && avg_done && cmp_ok;
        cal_set    = PRIMARY && cal_done;
        set_evt    = single_set || avg_set || cal_set;
        clr_evt    = clr_wr || clr_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_EMPTY: if (set_evt)             state_d = FLG_DONE;
            FLG_DONE:  if (clr_evt && !set_evt) state_d = FLG_EMPTY;
            default:                            state_d = FLG_EMPTY;
        endcase
    end

    always_comb begin
        flag = (state_q == FLG_DONE);
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !flag);
    // R2
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_evt && !set_evt) |=> $stable(flag));
    // R4
    avg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_en && !avg_done && !cal_done && !flag) |=> !flag);

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              cont_mode,
    input  logic              conv_done,
    output logic              conv_start
);

    seq_state_t state_q, state_d;
    logic       start_q, start_d;
    logic       wr_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_OFF;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= start_d;
        end
    end

    always_comb begin
        wr_off  = (wr_code == OFF_CODE);
        state_d = state_q;
        start_d = 1'b0;
        if (wr_en) begin
            state_d = wr_off ? SEQ_OFF : SEQ_BUSY;
            start_d = !wr_off;
        end else begin
            unique case (state_q)
                SEQ_OFF:  state_d = SEQ_OFF;
                SEQ_IDLE: state_d = SEQ_IDLE;
                SEQ_BUSY: begin
                    if (conv_done) begin
                        state_d = cont_mode ? SEQ_BUSY : SEQ_IDLE;
                        start_d = cont_mode;
                    end
                end
                default:  state_d = SEQ_OFF;
            endcase
        end
    end

    always_comb begin
        conv_start = start_q;
    end

    // R8
    wr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_off) |=> conv_start);
    // R8
    off_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off) |=> (!conv_start && state_q == SEQ_OFF));
    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (state_q == SEQ_BUSY));

endmodule

// File: rtl/adc_chan_decode.sv
module adc_chan_decode
    import adc_chan_pkg::*;
#(
    parameter int NUM_SE   = 8,
    parameter int NUM_DIFF = 4
) (
    input  cfg_t                cfg,
    output logic [NUM_SE-1:0]   sel_se,
    output logic [NUM_DIFF-1:0] sel_pair,
    output logic                sel_rsvd,
    output logic                conv_off
);

    localparam logic [CODE_W-1:0] DIFF_LIM = CODE_W'(NUM_DIFF);
    localparam logic [CODE_W-1:0] SE_LIM   = CODE_W'(NUM_SE);

    for (genvar i = 0; i < NUM_SE; i++) begin : g_se
        localparam logic [CODE_W-1:0] K = CODE_W'(i);
        assign sel_se[i] = !cfg.diff && (cfg.code == K);
    end

    for (genvar j = 0; j < NUM_DIFF; j++) begin : g_pair
        localparam logic [CODE_W-1:0] K = CODE_W'(j);
        assign sel_pair[j] = cfg.diff && (cfg.code == K);
    end

    assign sel_rsvd = cfg.diff && (cfg.code >= DIFF_LIM) && (cfg.code < SE_LIM);
    assign conv_off = (cfg.code == OFF_CODE);

    // R10
    onehot_sel_chk: assert final ($onehot0({sel_se, sel_pair}));
    // R10
    off_isolate_chk: assert final (!conv_off || ({sel_se, sel_pair, sel_rsvd} == '0));

endmodule

// File: rtl/adc_chan_ctrl.sv
module adc_chan_ctrl
    import adc_chan_pkg::*;
#(
    parameter bit PRIMARY  = 1'b1,
    parameter int NUM_SE   = 8,
    parameter int NUM_DIFF = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    input  logic                res_rd,
    input  logic                cont_mode,
    input  logic                cmp_en,
    input  logic                avg_en,
    input  logic                conv_done,
    input  logic                cmp_true,
    input  logic                avg_done,
    input  logic                cal_done,
    output logic                irq,
    output logic                conv_start,
    output logic                conv_off,
    output logic [NUM_SE-1:0]   sel_se,
    output logic [NUM_DIFF-1:0] sel_pair,
    output logic                sel_rsvd
);

    cfg_t cfg;
    logic flag;
    logic wr_rsvd_unused;

    assign wr_rsvd_unused = ^wr_data[REG_W-1:FLAG_B];

    adc_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_cfg (wr_data[CFG_W-1:0]),
        .cfg    (cfg)
    );

    adc_done_flag #(.PRIMARY(PRIMARY)) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_en    (cmp_en),
        .avg_en    (avg_en),
        .conv_done (conv_done),
        .cmp_true  (cmp_true),
        .avg_done  (avg_done),
        .cal_done  (cal_done),
        .clr_wr    (wr_en),
        .clr_rd    (res_rd),
        .flag      (flag)
    );

    adc_conv_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_code    (wr_data[CODE_W-1:0]),
        .cont_mode  (cont_mode),
        .conv_done  (conv_done),
        .conv_start (conv_start)
    );

    adc_chan_decode #(.NUM_SE(NUM_SE), .NUM_DIFF(NUM_DIFF)) u_dec (
        .cfg      (cfg),
        .sel_se   (sel_se),
        .sel_pair (sel_pair),
        .sel_rsvd (sel_rsvd),
        .conv_off (conv_off)
    );

    always_comb begin
        rd_data         = '0;
        rd_data[FLAG_B] = flag;
        rd_data[IEN_B]  = cfg.ien;
        rd_data[DIFF_B] = cfg.diff;
        rd_data[CODE_W-1:0] = cfg.code;
        irq             = flag && cfg.ien;
    end

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (flag && cfg.ien));
    // R1
    wr_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !conv_done && !avg_done && !cal_done) |=> !flag);

endmodule

// File: tb/tb_adc_chan_ctrl.sv
module tb_adc_chan_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        res_rd = 1'b0, cont_mode = 1'b0, cmp_en = 1'b0, avg_en = 1'b0;
    logic        conv_done = 1'b0, cmp_true = 1'b0, avg_done = 1'b0, cal_done = 1'b0;
    logic        irq, conv_start, conv_off, sel_rsvd;
    logic [7:0]  sel_se;
    logic [3:0]  sel_pair;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // behavioural model state
    bit m_flag = 0, m_en = 0, m_diff = 0, m_start = 0;
    int m_code = 31;
    string m_seq = "off";

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_chan_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .res_rd(res_rd), .cont_mode(cont_mode), .cmp_en(cmp_en), .avg_en(avg_en),
        .conv_done(conv_done), .cmp_true(cmp_true), .avg_done(avg_done), .cal_done(cal_done),
        .irq(irq), .conv_start(conv_start), .conv_off(conv_off),
        .sel_se(sel_se), .sel_pair(sel_pair), .sel_rsvd(sel_rsvd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd();
        return {24'd0, m_flag, m_en, m_diff, 5'(m_code)};
    endfunction

    function automatic logic [7:0] exp_se();
        return (!m_diff && m_code < 8) ? 8'(1 << m_code) : 8'd0;
    endfunction

    function automatic logic [3:0] exp_pair();
        return (m_diff && m_code < 4) ? 4'(1 << m_code) : 4'd0;
    endfunction

    task automatic compare_all();
        check("R1 rd_data",     rd_data, exp_rd());
        check("R7 irq",         32'(irq), 32'(m_flag && m_en));
        check("R8/R9 start",    32'(conv_start), 32'(m_start));
        check("R8 conv_off",    32'(conv_off), 32'(m_code == 31));
        check("R10 sel_se",     32'(sel_se), 32'(exp_se()));
        check("R10 sel_pair",   32'(sel_pair), 32'(exp_pair()));
        check("R10 sel_rsvd",   32'(sel_rsvd), 32'(m_diff && m_code >= 4 && m_code < 8));
    endtask

    // Apply currently driven inputs for one clock and compare at the next falling edge.
    task automatic tick();
        bit set, clr, nflag, nstart;
        string nseq;
        bit cmp_ok;
        cmp_ok = !cmp_en || cmp_true;
        set = (!avg_en && conv_done && cmp_ok) || (avg_en && avg_done && cmp_ok) || cal_done;
        clr = wr_en || res_rd;
        nflag = set ? 1'b1 : (clr ? 1'b0 : m_flag);
        nseq = m_seq;
        nstart = 0;
        if (wr_en) begin
            if (wr_data[4:0] == 5'h1F) nseq = "off";
            else begin nseq = "busy"; nstart = 1; end
        end else if (m_seq == "busy" && conv_done) begin
            if (cont_mode) nstart = 1; else nseq = "idle";
        end
        @(posedge clk);
        m_flag = nflag;
        m_seq = nseq;
        m_start = nstart;
        if (wr_en) begin
            m_en = wr_data[6];
            m_diff = wr_data[5];
            m_code = int'(wr_data[4:0]);
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        wr_en = 0; res_rd = 0; conv_done = 0; avg_done = 0; cal_done = 0; cmp_true = 0;
    endtask

    task automatic bus_wr(input logic [31:0] d);
        wr_en = 1; wr_data = d; tick(); wr_en = 0;
    endtask

    task automatic pulse_conv(input bit ct);
        conv_done = 1; cmp_true = ct; tick(); conv_done = 0; cmp_true = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 rd_data reset", rd_data, 32'h0000_001F);
        check("R11 irq reset", 32'(irq), 32'd0);
        check("R11 start reset", 32'(conv_start), 32'd0);
        check("R11 off reset", 32'(conv_off), 32'd1);
        rst_n = 1;
        @(negedge clk);

        // R8 write single-ended code 5 with enable: start pulse, select line 5
        bus_wr(32'h0000_0045);
        check("R8 start after write", 32'(conv_start), 32'd1);
        check("R10 se5", 32'(sel_se), 32'h20);
        tick();
        check("R8 start one cycle", 32'(conv_start), 32'd0);

        // R2 plain completion sets flag and R7 irq
        pulse_conv(0);
        check("R2 flag set", 32'(rd_data[7]), 32'd1);
        check("R7 irq on", 32'(irq), 32'd1);

        // R6 result read clears
        res_rd = 1; tick(); res_rd = 0;
        check("R6 clear by read", 32'(rd_data[7]), 32'd0);

        // R6 set wins over simultaneous clear
        res_rd = 1; conv_done = 1; tick(); idle_inputs();
        check("R6 set wins", 32'(rd_data[7]), 32'd1);

        // R1 write with bit7 and reserved bits high: clears flag, upper bits read 0, pair 2
        bus_wr(32'hFFFF_FFA2);
        check("R1 write clears, reserved zero", rd_data, 32'h0000_0022);
        check("R10 pair2", 32'(sel_pair), 32'h4);
        tick();

        // R3 compare qualification
        cmp_en = 1;
        pulse_conv(0);
        check("R3 compare false no flag", 32'(rd_data[7]), 32'd0);
        pulse_conv(1);
        check("R3 compare true flag", 32'(rd_data[7]), 32'd1);
        res_rd = 1; tick(); res_rd = 0;
        cmp_en = 0;

        // R4 averaging: conv_done ignored, avg_done sets
        avg_en = 1;
        pulse_conv(1);
        check("R4 conv ignored in avg", 32'(rd_data[7]), 32'd0);
        avg_done = 1; tick(); avg_done = 0;
        check("R4 avg set", 32'(rd_data[7]), 32'd1);
        res_rd = 1; tick(); res_rd = 0;
        cmp_en = 1;
        avg_done = 1; cmp_true = 0; tick(); idle_inputs();
        check("R4 avg with compare false", 32'(rd_data[7]), 32'd0);
        avg_en = 0; cmp_en = 0;

        // R5 calibration completion
        cal_done = 1; tick(); cal_done = 0;
        check("R5 cal sets flag", 32'(rd_data[7]), 32'd1);

        // R10 reserved differential code
        bus_wr(32'h0000_0026);
        check("R10 reserved diff", 32'(sel_rsvd), 32'd1);
        check("R10 no select", 32'({sel_se, sel_pair}), 32'd0);

        // R9 continuous run and its termination
        cont_mode = 1;
        bus_wr(32'h0000_0003);
        tick();
        pulse_conv(0);
        check("R9 continuous restart", 32'(conv_start), 32'd1);
        bus_wr(32'h0000_001F);
        check("R8 off write no start", 32'(conv_start), 32'd0);
        check("R8 off", 32'(conv_off), 32'd1);
        pulse_conv(0);
        check("R9 no extra sample", 32'(conv_start), 32'd0);
        cont_mode = 0;

        // mixed pseudo-random traffic, compared against the model each cycle
        for (int i = 0; i < 600; i++) begin
            wr_en     = ($urandom_range(0, 9) == 0);
            wr_data   = $urandom;
            if ($urandom_range(0, 5) == 0) wr_data[4:0] = 5'h1F;
            res_rd    = ($urandom_range(0, 7) == 0);
            conv_done = ($urandom_range(0, 3) == 0);
            cmp_true  = $urandom_range(0, 1) == 1;
            avg_done  = ($urandom_range(0, 5) == 0);
            cal_done  = ($urandom_range(0, 15) == 0);
            if (i % 50 == 0) begin
                cont_mode = $urandom_range(0, 1) == 1;
                cmp_en    = $urandom_range(0, 1) == 1;
                avg_en    = $urandom_range(0, 1) == 1;
            end
            tick();
        end
        idle_inputs();
        tick();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule